// File: doc/BRIEF.md
# Programmable Synchronous Serial Byte Master

This block moves one byte at a time across a three-wire serial link: a shared bidirectional data line, a serial clock it generates, and an active-low select it drives. The host pulses `start` with a direction flag, a transmit byte, a clock divider setting, a bit-order flag and a minimum idle gap. The block then runs one 8-bit frame. When the frame ends, it pulses `done` for one cycle. On a receive frame, `rx_byte` holds the captured data from that cycle on. Any framing above the byte level, such as command bytes or the byte count and direction per command, is left to the host.

The serial clock runs at the system clock divided by 2^(div_sel+1). It toggles only inside a frame and rests high otherwise. Each bit starts with a low half period and ends with a high half period. The master puts write data on the line at the falling edge and samples read data at the rising edge. After a frame the select stays released for a programmable number of system clocks before another frame may begin.

The controller has four states. IDLE waits for `start`. SHIFT_LO is the low half of a bit. SHIFT_HI is the high half of a bit. GAP holds the select released. The transitions are:
- IDLE to SHIFT_LO on `start`. The settings are latched at this point.
- SHIFT_LO to SHIFT_HI at the end of a half period. Read data is sampled here.
- SHIFT_HI to SHIFT_LO at the end of a half period when more bits remain.
- SHIFT_HI to GAP after the last bit when the latched gap is non-zero.
- SHIFT_HI to IDLE after the last bit when the latched gap is zero.
- GAP to IDLE when the gap count runs out.

Top module: `sync_serial_master`

## Requirements
- R1: After reset `sclk`=1, `sel_n`=1, `sd_oe`=0, `done`=0, `busy`=0 and `rx_byte`=0.
- R2: A `start` sampled in IDLE drives `sel_n` low from the next cycle for exactly 16·2^div_sel system clocks. `busy` is high from then until the block returns to IDLE.
- R3: Within a frame `sclk` is low for 2^div_sel cycles and then high for 2^div_sel cycles, for each of exactly 8 bits. Outside a frame `sclk` is 1.
- R4: With `msb_first`=0, bit 0 is moved first and bit 7 last. With `msb_first`=1, bit 7 is moved first. The same order applies to both directions.
- R5: On a write frame (`rd`=0), `sd_oe` is 1 for the whole frame. `sd_out` changes only as `sclk` falls, so a slave sampling at the rising edges receives `tx_byte`.
- R6: On a read frame (`rd`=1), `sd_oe` stays 0. `sd_in` is sampled at each rising `sclk` edge, and `rx_byte` receives the assembled byte.
- R7: `done` is high for exactly one cycle, which is the first cycle with `sel_n` high after the frame. `rx_byte` changes only in that cycle and only on read frames.
- R8: After a frame `sel_n` stays high for at least gap_cycles+1 cycles. If `start` is held, the next frame begins exactly after gap_cycles+1 cycles.
- R9: `start` is ignored while `busy` is high. `rd`, `tx_byte`, `div_sel`, `msb_first` and `gap_cycles` are latched at start, so changes during a frame have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a byte frame (taken only in IDLE) |
| rd | input | 1 | 1 = receive frame, 0 = transmit frame |
| tx_byte | input | DATA_W | Byte to transmit |
| div_sel | input | DIV_W | Serial clock = clk / 2^(div_sel+1) |
| msb_first | input | 1 | 1 = most significant bit first, 0 = least significant first |
| gap_cycles | input | GAP_W | Minimum extra idle clocks after a frame |
| rx_byte | output | DATA_W | Last received byte |
| done | output | 1 | One-cycle end-of-frame pulse |
| busy | output | 1 | Frame or gap in progress |
| sclk | output | 1 | Serial clock, idles high |
| sel_n | output | 1 | Active-low select for the frame |
| sd_out | output | 1 | Serial data towards the pad |
| sd_oe | output | 1 | Pad output enable for the data line |
| sd_in | input | 1 | Serial data from the pad |

## Verification
The bench covers the following corner cases, and what each catches:
- The fastest divider setting (one-cycle half periods) and the slowest one. An off-by-one in the phase counter gives a frame that is a cycle or a whole half period too long.
- Both bit orders in both directions. A reversed or shared index mux mirrors the byte in only one direction.
- A `start` held through a frame and its gap, with gaps of zero and non-zero. A block that honoured `start` while busy would cut the gap short or restart mid-frame.
- Settings scrambled mid-frame, which would corrupt data or timing if they were not latched.
- Write frames checked to leave `rx_byte` unchanged.

// File: rtl/ssm_pkg.sv
package ssm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOW   = 2'd1,
        ST_HIGH  = 2'd2,
        ST_GAP   = 2'd3
    } ssm_state_e;

endpackage

// File: rtl/ssm_phase_ctr.sv
module ssm_phase_ctr #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_sel,
    output logic             phase_end
);
    localparam int CNT_W = 1 << DIV_W;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] half_max;

    assign half_max  = (CNT_W'(1) << div_sel) - CNT_W'(1);
    assign phase_end = run && (cnt == half_max);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || phase_end)
            cnt <= '0;
        else
            cnt <= cnt + CNT_W'(1);
    end
endmodule

// File: rtl/ssm_gap_ctr.sv
module ssm_gap_ctr #(
    parameter int GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [GAP_W-1:0] load_val,
    input  logic             run,
    output logic             expire
);
    logic [GAP_W-1:0] cnt;

    assign expire = (cnt <= GAP_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (run && cnt != '0)
            cnt <= cnt - GAP_W'(1);
    end
endmodule

// File: rtl/sync_serial_master.sv
module sync_serial_master
    import ssm_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 3,
    parameter int GAP_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              rd,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic [DIV_W-1:0]  div_sel,
    input  logic              msb_first,
    input  logic [GAP_W-1:0]  gap_cycles,
    output logic [DATA_W-1:0] rx_byte,
    output logic              done,
    output logic              busy,
    output logic              sclk,
    output logic              sel_n,
    output logic              sd_out,
    output logic              sd_oe,
    input  logic              sd_in
);
    localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

    ssm_state_e        state, state_nx;
    logic [DATA_W-1:0] tx_q, rx_sh, rx_q;
    logic              rd_q, msb_q, done_q;
    logic [DIV_W-1:0]  div_q;
    logic [GAP_W-1:0]  gap_q;
    logic [BIT_W-1:0]  bit_idx, bit_pos;
    logic              in_frame, phase_end, gap_expire, last_half;

    assign in_frame  = (state == ST_LOW) || (state == ST_HIGH);
    assign bit_pos   = msb_q ? (LAST_BIT - bit_idx) : bit_idx;
    assign last_half = (state == ST_HIGH) && phase_end && (bit_idx == LAST_BIT);

    ssm_phase_ctr #(.DIV_W(DIV_W)) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (in_frame),
        .div_sel   (div_q),
        .phase_end (phase_end)
    );

    ssm_gap_ctr #(.GAP_W(GAP_W)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (last_half),
        .load_val (gap_q),
        .run      (state == ST_GAP),
        .expire   (gap_expire)
    );

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = ST_LOW;
            ST_LOW:  if (phase_end) state_nx = ST_HIGH;
            ST_HIGH: begin
                if (phase_end) begin
                    if (bit_idx != LAST_BIT)  state_nx = ST_LOW;
                    else if (gap_q == '0)     state_nx = ST_IDLE;
                    else                      state_nx = ST_GAP;
                end
            end
            ST_GAP:  if (gap_expire) state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q    <= '0;
            rx_sh   <= '0;
            rx_q    <= '0;
            rd_q    <= 1'b0;
            msb_q   <= 1'b0;
            div_q   <= '0;
            gap_q   <= '0;
            bit_idx <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (state == ST_IDLE && start) begin
                tx_q    <= tx_byte;
                rd_q    <= rd;
                msb_q   <= msb_first;
                div_q   <= div_sel;
                gap_q   <= gap_cycles;
                bit_idx <= '0;
            end
            if (state == ST_LOW && phase_end && rd_q)
                rx_sh[bit_pos] <= sd_in;
            if (state == ST_HIGH && phase_end) begin
                if (bit_idx == LAST_BIT) begin
                    done_q <= 1'b1;
                    if (rd_q) rx_q <= rx_sh;
                end else begin
                    bit_idx <= bit_idx + BIT_W'(1);
                end
            end
        end
    end

    // outputs
    always_comb begin
        sclk    = (state != ST_LOW);
        sel_n   = !in_frame;
        sd_oe   = in_frame && !rd_q;
        sd_out  = sd_oe ? tx_q[bit_pos] : 1'b0;
        busy    = (state != ST_IDLE);
        done    = done_q;
        rx_byte = rx_q;
    end
endmodule

// File: rtl/sync_serial_master_chk.sv
module sync_serial_master_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sclk,
    input logic              sel_n,
    input logic              sd_oe,
    input logic              sd_out,
    input logic              done,
    input logic              busy,
    input logic [DATA_W-1:0] rx_byte
);
    logic       sclk_d;
    logic [4:0] rise_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d   <= 1'b1;
            rise_cnt <= '0;
        end else begin
            sclk_d <= sclk;
            if (sel_n)
                rise_cnt <= '0;
            else if (sclk && !sclk_d)
                rise_cnt <= rise_cnt + 5'd1;
        end
    end

    a_r3_idle_clk_high: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |-> sclk);

    a_r3_eight_rises: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_n) |-> (rise_cnt == 5'd8));

    a_r2_busy_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_n |-> busy);

    a_r5_data_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_oe && $past(sd_oe) && !$fell(sclk)) |-> $stable(sd_out));

    a_r6_oe_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        sd_oe |-> !sel_n);

    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_done_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (sel_n && $past(!sel_n)));

    a_r7_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(rx_byte));
endmodule

bind sync_serial_master sync_serial_master_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sclk    (sclk),
    .sel_n   (sel_n),
    .sd_oe   (sd_oe),
    .sd_out  (sd_out),
    .done    (done),
    .busy    (busy),
    .rx_byte (rx_byte)
);

// File: tb/sync_serial_master_tb.sv
`timescale 1ns/1ps
module sync_serial_master_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0, rd = 1'b0, msb_first = 1'b0, sd_in = 1'b0;
    logic [7:0] tx_byte = '0, gap_cycles = '0;
    logic [2:0] div_sel = '0;
    logic [7:0] rx_byte;
    logic       done, busy, sclk, sel_n, sd_out, sd_oe;

    int checks = 0, errors = 0;
    int hi_run = 0, last_gap = 0, lo_cnt = 0, oe_cnt = 0;
    logic [7:0] s_tx = '0, s_cap = '0;
    int  s_rise = 0;
    bit  s_msb = 1'b0;

    always #2.5 clk = ~clk;

    sync_serial_master u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .rd(rd), .tx_byte(tx_byte),
        .div_sel(div_sel), .msb_first(msb_first), .gap_cycles(gap_cycles),
        .rx_byte(rx_byte), .done(done), .busy(busy), .sclk(sclk), .sel_n(sel_n),
        .sd_out(sd_out), .sd_oe(sd_oe), .sd_in(sd_in)
    );

    function automatic int bpos(bit msb, int i);
        return msb ? 7 - i : i;
    endfunction

    function automatic int frame_len(logic [2:0] dv);
        return 16 << dv;
    endfunction

    // slave model: drives on falling sclk, samples on rising sclk
    always @(negedge sclk) if (s_rise < 8) sd_in = s_tx[bpos(s_msb, s_rise)];
    always @(posedge sclk) if (s_rise < 8 && rst_n) begin
        s_cap[bpos(s_msb, s_rise)] = sd_out;
        s_rise++;
    end

    always @(negedge clk) begin
        if (sel_n) hi_run++;
        else begin
            if (hi_run != 0) last_gap = hi_run;
            hi_run = 0;
            lo_cnt++;
        end
        if (sd_oe) oe_cnt++;
    end

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic xfer(bit r, logic [7:0] tx, logic [7:0] sb, logic [2:0] dv,
                        bit msb, logic [7:0] gp, bit hold, bit chained, int exp_hi);
        int cnt;
        logic [7:0] rx_before;
        rx_before  = rx_byte;
        rd = r; tx_byte = tx; div_sel = dv; msb_first = msb; gap_cycles = gp;
        s_tx = sb; s_msb = msb; s_rise = 0; s_cap = '0;
        lo_cnt = 0; oe_cnt = 0;
        start = 1'b1;
        do @(negedge clk); while (sel_n);
        cnt = 1;
        if (!hold) begin
            start = 1'b0;
            tx_byte = ~tx; div_sel = ~dv; msb_first = ~msb; rd = ~r; // R9: must be ignored
        end
        while (!done) begin @(negedge clk); cnt++; end
        chk(cnt == frame_len(dv) + 1, "R2", "done latency", cnt, frame_len(dv) + 1);
        chk(lo_cnt == frame_len(dv), "R2", "sel_n low cycles", lo_cnt, frame_len(dv));
        chk(s_rise == 8, "R3", "sclk rising edges", s_rise, 8);
        if (r) begin
            chk(rx_byte == sb, msb ? "R4" : "R6", "rx_byte", rx_byte, sb);
            chk(oe_cnt == 0, "R6", "oe cycles on read", oe_cnt, 0);
        end else begin
            chk(s_cap == tx, msb ? "R4" : "R5", "slave captured", s_cap, tx);
            chk(oe_cnt == frame_len(dv), "R5", "oe cycles on write", oe_cnt, frame_len(dv));
            chk(rx_byte == rx_before, "R7", "rx_byte kept on write", rx_byte, rx_before);
        end
        if (chained) chk(last_gap == exp_hi, "R8", "gap cycles", last_gap, exp_hi);
        if (!hold) begin
            @(negedge clk);
            chk(done == 1'b0, "R7", "done width", done, 0);
            while (busy) @(negedge clk);
            chk(sclk && sel_n, "R3", "idle sclk/sel_n", {sclk, sel_n}, 3);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sclk == 1 && sel_n == 1, "R1", "idle lines", {sclk, sel_n}, 3);
        chk(sd_oe == 0 && done == 0 && busy == 0, "R1", "oe/done/busy", {sd_oe, done, busy}, 0);
        chk(rx_byte == 0, "R1", "rx_byte", rx_byte, 0);

        xfer(0, 8'hA5, 8'h00, 3'd0, 0, 8'd0, 0, 0, 0);
        xfer(1, 8'h00, 8'h3C, 3'd1, 1, 8'd2, 0, 0, 0);
        xfer(1, 8'h00, 8'h01, 3'd0, 0, 8'd0, 0, 0, 0);
        xfer(1, 8'h00, 8'h01, 3'd0, 1, 8'd0, 0, 0, 0);
        xfer(0, 8'h81, 8'h00, 3'd7, 1, 8'd1, 0, 0, 0);
        xfer(1, 8'h00, 8'h5A, 3'd7, 0, 8'd0, 0, 0, 0);

        // back-to-back with start held (R8, R9)
        xfer(0, 8'h0F, 8'h00, 3'd1, 0, 8'd3, 1, 0, 0);
        xfer(1, 8'h00, 8'hC3, 3'd0, 1, 8'd0, 1, 1, 4);
        xfer(0, 8'h96, 8'h00, 3'd2, 0, 8'd5, 1, 1, 1);
        xfer(1, 8'h00, 8'h2B, 3'd0, 0, 8'd0, 0, 1, 6);

        for (int i = 0; i < 40; i++) begin
            xfer(1'($urandom % 2), 8'($urandom), 8'($urandom), 3'($urandom % 4),
                 1'($urandom % 2), 8'($urandom % 8), 0, 0, 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule